// File: doc/BRIEF.md
# Byte Register File with Word Pointer Ports

This block is the general register store of a small pipelined 8-bit processor core. It holds 32 byte-wide registers. Two read ports can run at the same time, and each captures a byte into an output register on the rising clock edge. One byte write port updates any single register.

The six highest registers also act as three 16-bit address pointers, called X, Y and Z. Each pointer is always visible on its own 16-bit output. Each pointer can be loaded as a whole word through its own write port. The word ports and the byte port share the same storage. When both write the same register in the same cycle, a fixed priority decides which one takes effect.

There are two resets. An active-low asynchronous reset and a synchronous clear both set all state to zero.

Top module: `rf_ptr_regfile`

## Requirements
- R1: When `wr_en_i` is high at a rising edge, the register at `wr_addr_i` (0 to 31) takes `wr_data_i`. The new value can be read from the next cycle onward.
- R2: A read port whose enable is high at a rising edge loads its data output with the register at its address. The new value appears after that edge.
- R3: A read port whose enable is low at a rising edge keeps its data output unchanged.
- R4: A read of a register that is being written at the same edge returns the value from before the write.
- R5: X is made of registers 26 (low byte) and 27 (high byte). Y is made of registers 28 (low) and 29 (high). Z is made of registers 30 (low) and 31 (high). Each pointer output follows its pair of registers, so a byte write to register 26 to 31 shows on the pointer output after that edge.
- R6: A pointer write enable that is high at an edge loads both bytes of that pointer from its 16-bit data input in one cycle. The bytes are then readable through the read ports.
- R7: A byte write to a pointer register changes only the addressed byte. The other byte of the pair is left as it was.
- R8: Both read ports, the byte write port and all three pointer write ports work correctly when they are all active in the same cycle, as long as they target different registers.
- R9: When a pointer write and a byte write target the same register in the same cycle, the pointer write takes effect and the byte write is discarded.
- R10: When `wr_en_i` is low, the byte write inputs have no effect on any register.
- R11: While `rst_ni` is low, every register, every pointer output and both read outputs are zero, without waiting for a clock edge.
- R12: When `srst_i` is high at an edge, every register and both read outputs become zero. This overrides any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear, active high |
| rd_a_en_i | input | 1 | Read port A enable |
| rd_a_addr_i | input | 5 | Read port A address |
| rd_a_data_o | output | 8 | Read port A registered data |
| rd_b_en_i | input | 1 | Read port B enable |
| rd_b_addr_i | input | 5 | Read port B address |
| rd_b_data_o | output | 8 | Read port B registered data |
| wr_en_i | input | 1 | Byte write enable |
| wr_addr_i | input | 5 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| ptr_x_we_i | input | 1 | X word write enable |
| ptr_x_wdata_i | input | 16 | X word write data |
| ptr_x_o | output | 16 | X pointer value |
| ptr_y_we_i | input | 1 | Y word write enable |
| ptr_y_wdata_i | input | 16 | Y word write data |
| ptr_y_o | output | 16 | Y pointer value |
| ptr_z_we_i | input | 1 | Z word write enable |
| ptr_z_wdata_i | input | 16 | Z word write data |
| ptr_z_o | output | 16 | Z pointer value |

## Verification
Each write and each enabled read takes effect at the first rising edge after it is presented. Read data and pointer values are therefore due one edge later. A write followed by a read of the same register needs two edges before the new value is seen. The asynchronous reset acts at once, with no edge. The bench changes inputs on the falling edge, lets one rising edge pass, and samples at the next falling edge. A value expected after a write-then-read is checked only after the second edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned DATA_W   = 8;
  parameter int unsigned NUM_REGS = 32;
  parameter int unsigned NUM_PTRS = 3;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);
  localparam int unsigned PTR_W    = 2 * DATA_W;
  localparam int unsigned PTR_BASE = NUM_REGS - 2 * NUM_PTRS;
endpackage

// File: rtl/rf_wr_select.sv
// Per-entry write enable and data; the word write beats the byte write.
module rf_wr_select #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_PTRS = 3,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned PTR_W   = 2 * DATA_W,
  localparam int unsigned PTR_BASE = NUM_REGS - 2 * NUM_PTRS
) (
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  input  logic [NUM_PTRS-1:0]                ptr_we_i,
  input  logic [NUM_PTRS-1:0][PTR_W-1:0]     ptr_wdata_i,
  output logic [NUM_REGS-1:0]                ent_we_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    ent_wd_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    logic byte_hit;
    assign byte_hit = wr_en_i && (wr_addr_i == ADDR_W'(i));
    if (i >= PTR_BASE) begin : g_ptr
      localparam int unsigned P    = (i - PTR_BASE) / 2;
      localparam int unsigned HALF = (i - PTR_BASE) % 2;
      assign ent_we_o[i] = ptr_we_i[P] || byte_hit;
      assign ent_wd_o[i] = ptr_we_i[P] ? ptr_wdata_i[P][HALF*DATA_W +: DATA_W] : wr_data_i;
    end else begin : g_gen
      assign ent_we_o[i] = byte_hit;
      assign ent_wd_o[i] = wr_data_i;
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            srst_i,
  input  logic [NUM_REGS-1:0]             ent_we_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] ent_wd_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          regs_o[i] <= '0;
      else if (srst_i)      regs_o[i] <= '0;
      else if (ent_we_i[i]) regs_o[i] <= ent_wd_i[i];
    end

    p_wr_commit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ent_we_i[i] && !srst_i) |=> regs_o[i] == $past(ent_wd_i[i]));
    p_no_wr_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ent_we_i[i] && !srst_i) |=> $stable(regs_o[i]));
    p_sync_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> regs_o[i] == '0);
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            srst_i,
  input  logic                            en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]               data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (srst_i) data_o <= '0;
    else if (en_i)   data_o <= regs_i[addr_i];
  end

  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !srst_i) |=> $stable(data_o));
  // old contents are returned even when the same entry is written this edge
  p_rd_old_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !srst_i) |=> data_o == $past(regs_i[addr_i]));
endmodule

// File: rtl/rf_ptr_regfile.sv
module rf_ptr_regfile
  import rf_pkg::*;
#(
  parameter int unsigned DW = rf_pkg::DATA_W,
  parameter int unsigned NR = rf_pkg::NUM_REGS,
  localparam int unsigned AW = $clog2(NR),
  localparam int unsigned PW = 2 * DW,
  localparam int unsigned NP = rf_pkg::NUM_PTRS,
  localparam int unsigned PB = NR - 2 * NP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          rd_a_en_i,
  input  logic [AW-1:0] rd_a_addr_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic          rd_b_en_i,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ptr_x_we_i,
  input  logic [PW-1:0] ptr_x_wdata_i,
  output logic [PW-1:0] ptr_x_o,
  input  logic          ptr_y_we_i,
  input  logic [PW-1:0] ptr_y_wdata_i,
  output logic [PW-1:0] ptr_y_o,
  input  logic          ptr_z_we_i,
  input  logic [PW-1:0] ptr_z_wdata_i,
  output logic [PW-1:0] ptr_z_o
);
  logic [NP-1:0]          ptr_we;
  logic [NP-1:0][PW-1:0]  ptr_wd;
  logic [NP-1:0][PW-1:0]  ptr_q;
  logic [NR-1:0]          ent_we;
  logic [NR-1:0][DW-1:0]  ent_wd;
  logic [NR-1:0][DW-1:0]  regs;

  assign ptr_we = {ptr_z_we_i, ptr_y_we_i, ptr_x_we_i};
  assign ptr_wd = {ptr_z_wdata_i, ptr_y_wdata_i, ptr_x_wdata_i};

  rf_wr_select #(.DATA_W(DW), .NUM_REGS(NR), .NUM_PTRS(NP)) u_sel (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .ptr_we_i   (ptr_we),
    .ptr_wdata_i(ptr_wd),
    .ent_we_o   (ent_we),
    .ent_wd_o   (ent_wd)
  );

  rf_storage #(.DATA_W(DW), .NUM_REGS(NR)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_i),
    .ent_we_i(ent_we),
    .ent_wd_i(ent_wd),
    .regs_o  (regs)
  );

  rf_rd_port #(.DATA_W(DW), .NUM_REGS(NR)) u_rd_a (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .srst_i(srst_i),
    .en_i  (rd_a_en_i),
    .addr_i(rd_a_addr_i),
    .regs_i(regs),
    .data_o(rd_a_data_o)
  );

  rf_rd_port #(.DATA_W(DW), .NUM_REGS(NR)) u_rd_b (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .srst_i(srst_i),
    .en_i  (rd_b_en_i),
    .addr_i(rd_b_addr_i),
    .regs_i(regs),
    .data_o(rd_b_data_o)
  );

  for (genvar p = 0; p < NP; p++) begin : g_ptr
    // even entry is the low byte
    assign ptr_q[p] = {regs[PB + 2*p + 1], regs[PB + 2*p]};

    p_ptr_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ptr_we[p] && !srst_i) |=> ptr_q[p] == $past(ptr_wd[p]));
    p_ptr_lo_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !srst_i && !ptr_we[p] && wr_addr_i == AW'(PB + 2*p))
      |=> $stable(ptr_q[p][PW-1:DW]));
    p_ptr_hi_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !srst_i && !ptr_we[p] && wr_addr_i == AW'(PB + 2*p + 1))
      |=> $stable(ptr_q[p][DW-1:0]));
  end

  assign ptr_x_o = ptr_q[0];
  assign ptr_y_o = ptr_q[1];
  assign ptr_z_o = ptr_q[2];

  p_clr_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (rd_a_data_o == '0 && rd_b_data_o == '0));
endmodule

// File: tb/tb_rf_ptr_regfile.sv
module tb_rf_ptr_regfile;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic srst_i = 1'b0;
  logic rd_a_en_i, rd_b_en_i, wr_en_i;
  logic [4:0] rd_a_addr_i, rd_b_addr_i, wr_addr_i;
  logic [7:0] rd_a_data_o, rd_b_data_o, wr_data_i;
  logic ptr_x_we_i, ptr_y_we_i, ptr_z_we_i;
  logic [15:0] ptr_x_wdata_i, ptr_y_wdata_i, ptr_z_wdata_i;
  logic [15:0] ptr_x_o, ptr_y_o, ptr_z_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rf_ptr_regfile dut (.*);

  // {addr, data}
  localparam logic [12:0] VEC [8] = '{
    {5'd0, 8'h11}, {5'd5, 8'hA5}, {5'd10, 8'h3C}, {5'd11, 8'hC3},
    {5'd17, 8'h7E}, {5'd25, 8'h81}, {5'd26, 8'h5A}, {5'd31, 8'hF0}};

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    srst_i = 0; wr_en_i = 0; wr_addr_i = 0; wr_data_i = 0;
    rd_a_en_i = 0; rd_a_addr_i = 0; rd_b_en_i = 0; rd_b_addr_i = 0;
    ptr_x_we_i = 0; ptr_y_we_i = 0; ptr_z_we_i = 0;
    ptr_x_wdata_i = 0; ptr_y_wdata_i = 0; ptr_z_wdata_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd2(logic [4:0] a, logic [4:0] b);
    idle();
    rd_a_en_i = 1; rd_a_addr_i = a; rd_b_en_i = 1; rd_b_addr_i = b;
    step();
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    idle();
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    step();
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    #1;
    chk("R11 reset rd_a", {8'h0, rd_a_data_o}, 16'h0);
    chk("R11 reset x", ptr_x_o, 16'h0);
    step(); step();
    rst_ni = 1;
    step();
    chk("R11 after release z", ptr_z_o, 16'h0);
    chk("R11 after release rd_b", {8'h0, rd_b_data_o}, 16'h0);

    // vector walk: write, then read on both ports
    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][12:8], VEC[k][7:0]);
      rd2(VEC[k][12:8], VEC[k][12:8]);
      chk("R1 R2 table rd_a", {8'h0, rd_a_data_o}, {8'h0, VEC[k][7:0]});
      chk("R2 table rd_b", {8'h0, rd_b_data_o}, {8'h0, VEC[k][7:0]});
    end
    chk("R5 R7 x from reg26", ptr_x_o, 16'h005A);
    chk("R5 R7 z from reg31", ptr_z_o, 16'hF000);

    // R3 hold
    idle(); rd_a_addr_i = 5'd0; rd_b_addr_i = 5'd5; step();
    chk("R3 hold rd_a", {8'h0, rd_a_data_o}, 16'h00F0);
    chk("R3 hold rd_b", {8'h0, rd_b_data_o}, 16'h00F0);

    // R4 read-during-write returns old value
    idle();
    wr_en_i = 1; wr_addr_i = 5'd10; wr_data_i = 8'h99;
    rd_a_en_i = 1; rd_a_addr_i = 5'd10; rd_b_en_i = 1; rd_b_addr_i = 5'd10;
    step();
    chk("R4 old rd_a", {8'h0, rd_a_data_o}, 16'h003C);
    chk("R4 old rd_b", {8'h0, rd_b_data_o}, 16'h003C);
    rd2(5'd10, 5'd11);
    chk("R4 new rd_a", {8'h0, rd_a_data_o}, 16'h0099);

    // R6 word writes
    idle();
    ptr_x_we_i = 1; ptr_x_wdata_i = 16'h1234;
    ptr_y_we_i = 1; ptr_y_wdata_i = 16'h5678;
    ptr_z_we_i = 1; ptr_z_wdata_i = 16'h9ABC;
    step();
    chk("R6 x", ptr_x_o, 16'h1234);
    chk("R6 y", ptr_y_o, 16'h5678);
    chk("R6 z", ptr_z_o, 16'h9ABC);
    rd2(5'd28, 5'd29);
    chk("R6 read y low", {8'h0, rd_a_data_o}, 16'h0078);
    chk("R6 read y high", {8'h0, rd_b_data_o}, 16'h0056);

    // R7 byte write to high byte only
    wr(5'd29, 8'hEE);
    chk("R7 y high only", ptr_y_o, 16'hEE78);

    // R8 everything at once, no conflicts
    idle();
    wr_en_i = 1; wr_addr_i = 5'd3; wr_data_i = 8'h33;
    rd_a_en_i = 1; rd_a_addr_i = 5'd28; rd_b_en_i = 1; rd_b_addr_i = 5'd3;
    ptr_x_we_i = 1; ptr_x_wdata_i = 16'h1111;
    ptr_y_we_i = 1; ptr_y_wdata_i = 16'h2222;
    ptr_z_we_i = 1; ptr_z_wdata_i = 16'h3333;
    step();
    chk("R8 rd_a", {8'h0, rd_a_data_o}, 16'h0078);
    chk("R8 rd_b", {8'h0, rd_b_data_o}, 16'h0000);
    chk("R8 x", ptr_x_o, 16'h1111);
    chk("R8 y", ptr_y_o, 16'h2222);
    chk("R8 z", ptr_z_o, 16'h3333);
    rd2(5'd3, 5'd17);
    chk("R8 byte landed", {8'h0, rd_a_data_o}, 16'h0033);
    chk("R8 other kept", {8'h0, rd_b_data_o}, 16'h007E);

    // R9 word write beats byte write on reg 31
    idle();
    wr_en_i = 1; wr_addr_i = 5'd31; wr_data_i = 8'h55;
    ptr_z_we_i = 1; ptr_z_wdata_i = 16'h4444;
    step();
    chk("R9 z wins", ptr_z_o, 16'h4444);
    // byte to reg 30 with an unrelated word write: both apply
    idle();
    wr_en_i = 1; wr_addr_i = 5'd30; wr_data_i = 8'h66;
    ptr_x_we_i = 1; ptr_x_wdata_i = 16'hABCD;
    step();
    chk("R9 R8 z low by byte", ptr_z_o, 16'h4466);
    chk("R9 R8 x by word", ptr_x_o, 16'hABCD);

    // R10 disabled write
    idle(); wr_addr_i = 5'd5; wr_data_i = 8'hFF; step();
    rd2(5'd5, 5'd0);
    chk("R10 no write", {8'h0, rd_a_data_o}, 16'h00A5);

    // R12 sync clear beats writes
    idle();
    srst_i = 1; wr_en_i = 1; wr_addr_i = 5'd10; wr_data_i = 8'h77;
    ptr_x_we_i = 1; ptr_x_wdata_i = 16'h7777;
    step();
    chk("R12 x cleared", ptr_x_o, 16'h0);
    chk("R12 z cleared", ptr_z_o, 16'h0);
    chk("R12 rd_a cleared", {8'h0, rd_a_data_o}, 16'h0);
    rd2(5'd10, 5'd5);
    chk("R12 reg10", {8'h0, rd_a_data_o}, 16'h0);
    chk("R12 reg5", {8'h0, rd_b_data_o}, 16'h0);

    // R11 async reset mid-run
    wr(5'd27, 8'hC1);
    rd2(5'd27, 5'd27);
    chk("R11 pre", ptr_x_o, 16'hC100);
    idle();
    rst_ni = 0;
    #1;
    chk("R11 async x", ptr_x_o, 16'h0);
    chk("R11 async rd_a", {8'h0, rd_a_data_o}, 16'h0);
    step();
    rst_ni = 1;
    step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule